// File: doc/BRIEF.md
# Page-Mode Flash Read Sequencer

This block sits on the host side of an asynchronous NOR-style memory that supports page-mode reads. A read request arrives with a word address on a valid/ready interface. The sequencer places the address on the memory bus and selects the device with chip enable and output enable, both active low. It then waits a fixed number of clock cycles and captures the data bus. The memory returns no ready handshake, so the sequencer alone decides when the data is safe to sample.

The memory groups words into pages of eight. The three least significant address bits pick a word inside a page, and the remaining bits name the page. The sequencer records which page is open. A read that lands in that page while the chip stays selected uses a short in-page wait. Any other read uses the long random-access wait. After a set number of idle cycles the sequencer deselects the chip, and that closes the page. Each response carries the captured word and a flag that says whether the short wait was used.

Top module: `pageflash_rdseq`

## Requirements
- R1: During and right after a synchronous reset, memCeN and memOeN are high, rspValid is low and reqReady is high.
- R2: The word offset within a page is reqAddr[2:0], and the page is reqAddr[ADDR_W-1:3]. A read to a different page, including the neighbouring page across an eight-word boundary, is served with the full wait.
- R3: A read that is not an in-page hit raises rspValid exactly FULL_WAIT cycles after the clock edge that accepts it, with rspInPage = 0.
- R4: A read to the open page while chip enable has stayed low raises rspValid exactly PAGE_WAIT cycles after acceptance, with rspInPage = 1. This includes a repeat of the same address.
- R5: After IDLE_LIMIT consecutive idle cycles in which no request is accepted, memCeN goes high and the open page is closed. A request accepted on the cycle that would otherwise drop chip enable still counts as an in-page hit.
- R6: After chip enable has been raised, the next read uses the full wait even if it targets the page, or the exact address, read before.
- R7: memOeN is low only while memCeN is low. memOeN is low for the whole of an access, and memAddr holds steady while memOeN stays low.
- R8: rspData equals the word on memData at the final wait cycle. rspValid lasts one cycle, and reqReady is low while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Read request present |
| reqAddr | input | ADDR_W | Word address of the request |
| reqReady | output | 1 | Sequencer can accept a request |
| rspValid | output | 1 | One-cycle pulse: response word is valid |
| rspData | output | DATA_W | Word returned by the memory |
| rspInPage | output | 1 | Response was served with the in-page wait |
| memAddr | output | ADDR_W | Word address to the memory |
| memCeN | output | 1 | Chip enable to the memory, active low |
| memOeN | output | 1 | Output enable to the memory, active low |
| memData | input | DATA_W | Data bus from the memory |

## Verification
For a request accepted at edge k, rspValid and rspData become visible just after edge k+FULL_WAIT for a random access, or k+PAGE_WAIT for an in-page hit. The driver stamps the acceptance cycle into each scoreboard entry. The monitor samples on falling edges and compares the elapsed cycle count against the wait the entry expects. The memory model in the bench returns a garbage word until the address has been held for the wait it requires, so sampling one cycle early shows up as a data mismatch. Idle gaps of IDLE_LIMIT-1 and IDLE_LIMIT cycles are counted in whole cycles from the response, so both sides of the chip-enable drop are checked.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadAddr;   // latch request address and page tag
    logic capture;    // sample the memory data bus
  } pfrStrobes_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } pfrState_e;

endpackage

// File: rtl/pfr_datapath.sv
module pfr_datapath
  import pfr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int OFFS_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  pfrStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] rspData,
  output logic              pageMatch
);

  localparam int PAGE_W = ADDR_W - OFFS_W;

  logic [PAGE_W-1:0] openPage;

  always_ff @(posedge clk) begin
    if (rst) begin
      memAddr  <= '0;
      openPage <= '0;
      rspData  <= '0;
    end else begin
      if (strobes.loadAddr) begin
        memAddr  <= reqAddr;
        openPage <= reqAddr[ADDR_W-1:OFFS_W];
      end
      if (strobes.capture) begin
        rspData <= memData;
      end
    end
  end

  assign pageMatch = (reqAddr[ADDR_W-1:OFFS_W] == openPage);

endmodule

// File: rtl/pfr_control.sv
module pfr_control
  import pfr_pkg::*;
#(
  parameter int FULL_WAIT  = 5,
  parameter int PAGE_WAIT  = 2,
  parameter int IDLE_LIMIT = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        pageMatch,
  output logic        reqReady,
  output pfrStrobes_t strobes,
  output logic        memCeN,
  output logic        memOeN,
  output logic        rspValid,
  output logic        rspInPage
);

  localparam int CNT_W  = $clog2(FULL_WAIT + 1);
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);

  pfrState_e         state;
  logic [CNT_W-1:0]  waitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              pageValid;
  logic              accept;
  logic              hit;
  logic              lastWait;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  // an open page implies chip enable is still low
  assign hit      = pageValid && pageMatch;
  assign lastWait = (state == ST_ACCESS) && (waitCnt == CNT_W'(1));

  always_comb begin
    strobes          = '0;
    strobes.loadAddr = accept;
    strobes.capture  = lastWait;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      idleCnt   <= '0;
      pageValid <= 1'b0;
      memCeN    <= 1'b1;
      memOeN    <= 1'b1;
      rspValid  <= 1'b0;
      rspInPage <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            memCeN    <= 1'b0;
            memOeN    <= 1'b0;
            waitCnt   <= hit ? CNT_W'(PAGE_WAIT) : CNT_W'(FULL_WAIT);
            rspInPage <= hit;
            pageValid <= 1'b1;
            idleCnt   <= '0;
            state     <= ST_ACCESS;
          end else if (!memCeN) begin
            if (idleCnt == IDLE_W'(IDLE_LIMIT - 1)) begin
              memCeN    <= 1'b1;
              pageValid <= 1'b0;
              idleCnt   <= '0;
            end else begin
              idleCnt <= idleCnt + IDLE_W'(1);
            end
          end
        end
        ST_ACCESS: begin
          if (lastWait) begin
            rspValid <= 1'b1;
            memOeN   <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pageflash_rdseq.sv
module pageflash_rdseq
  import pfr_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int FULL_WAIT  = 5,
  parameter int PAGE_WAIT  = 2,
  parameter int IDLE_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspInPage,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  input  logic [DATA_W-1:0] memData
);

  localparam int OFFS_W = 3;  // eight words per page

  pfrStrobes_t strobes;
  logic        pageMatch;

  pfr_control #(
    .FULL_WAIT (FULL_WAIT),
    .PAGE_WAIT (PAGE_WAIT),
    .IDLE_LIMIT(IDLE_LIMIT)
  ) u_control (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .pageMatch(pageMatch),
    .reqReady (reqReady),
    .strobes  (strobes),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .rspValid (rspValid),
    .rspInPage(rspInPage)
  );

  pfr_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFFS_W(OFFS_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .memData  (memData),
    .memAddr  (memAddr),
    .rspData  (rspData),
    .pageMatch(pageMatch)
  );

endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN
);

  // R1: reset leaves the memory deselected and no response
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (memCeN && memOeN && !rspValid));

  // R7: output enable only while selected
  p_oe_needs_ce_r7: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> !memCeN);

  // R7: address held while output enable stays low
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!memOeN && $past(!memOeN)) |-> $stable(memAddr));

  // R7: an accepted request starts a selected, enabled access
  p_accept_starts_r7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> (!memCeN && !memOeN));

  // R8: response is a single-cycle pulse
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  // R8: no new request while an access is running
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> !reqReady);

endmodule

bind pageflash_rdseq pfr_checker #(.ADDR_W(ADDR_W)) u_pfr_checker (
  .clk     (clk),
  .rst     (rst),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memOeN  (memOeN)
);

// File: tb/pageflash_rdseq_bench.sv
`timescale 1ns/1ps
module pageflash_rdseq_bench;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int FULL   = 5;
  localparam int PAGE   = 2;
  localparam int IDLE   = 6;
  localparam logic [DATA_W-1:0] JUNK = 16'hDEAD;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic              rspInPage;
  logic [ADDR_W-1:0] memAddr;
  logic              memCeN;
  logic              memOeN;
  logic [DATA_W-1:0] memData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pageflash_rdseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FULL_WAIT(FULL), .PAGE_WAIT(PAGE), .IDLE_LIMIT(IDLE)
  ) u_pageflash_rdseq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .rspInPage(rspInPage), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memData(memData)
  );

  function automatic logic [DATA_W-1:0] wordOf(input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = {12'd0, a} * 32'd40503 + 32'd4660;
    return t[DATA_W-1:0];
  endfunction

  // ---- memory model: data valid only after the required hold time ----
  logic [ADDR_W-1:0]   lastAddr = '0;
  logic                lastCeN  = 1'b1;
  int                  stab     = 0;
  logic                fastReg  = 1'b0;
  logic [ADDR_W-4:0]   mPage    = '0;
  logic                mOpen    = 1'b0;
  logic                curNew;
  logic                curFast;
  int                  effStab;
  int                  need;

  always_comb begin
    curNew  = !memCeN && ((memAddr != lastAddr) || lastCeN);
    curFast = curNew ? (mOpen && (memAddr[ADDR_W-1:3] == mPage)) : fastReg;
    effStab = curNew ? 0 : stab;
    need    = curFast ? PAGE : FULL;
    memData = (!memCeN && !memOeN && (effStab >= need - 1)) ? wordOf(memAddr) : JUNK;
  end

  always @(posedge clk) begin
    lastAddr <= memAddr;
    lastCeN  <= memCeN;
    if (memCeN) begin
      mOpen <= 1'b0;
    end else if (curNew) begin
      mOpen   <= 1'b1;
      mPage   <= memAddr[ADDR_W-1:3];
      fastReg <= curFast;
      stab    <= 1;
    end else if (stab < 1000) begin
      stab <= stab + 1;
    end
  end

  // ---- scoreboard ----
  typedef struct {
    logic [ADDR_W-1:0] addr;
    bit                hit;
    int                acc;
    string             tag;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // driver: wait gap idle cycles after ready, then issue one read
  task automatic doRead(input logic [ADDR_W-1:0] a, input bit expHit,
                        input int gap, input string tag);
    exp_t e;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    for (int i = 0; i < gap; i++) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    @(posedge clk);
    #1;
    e.addr = a; e.hit = expHit; e.acc = cyc; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
    // R7 R8: access under way
    check(!memCeN && !memOeN, "R7", "ce/oe low during access", {memCeN, memOeN}, 0);
    check(!reqReady, "R8", "ready low while busy", reqReady, 0);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          int lat;
          e = q.pop_front();
          lat = cyc - e.acc;
          check(rspData == wordOf(e.addr), "R8", {e.tag, " data"}, rspData, wordOf(e.addr));
          check(rspInPage == e.hit, e.hit ? "R4" : "R3", {e.tag, " inPage flag"},
                rspInPage, e.hit);
          check(lat == (e.hit ? PAGE : FULL), e.hit ? "R4" : "R3", {e.tag, " latency"},
                lat, e.hit ? PAGE : FULL);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 100000);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while held
    check(memCeN && memOeN, "R1", "ce/oe during reset", {memCeN, memOeN}, 3);
    check(!rspValid, "R1", "rspValid during reset", rspValid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(memCeN && memOeN && !rspValid, "R1", "state after reset",
          {memCeN, memOeN, rspValid}, 6);
    check(reqReady, "R1", "ready after reset", reqReady, 1);

    // R3: first read is a random access
    doRead(20'h00123, 1'b0, 0, "R3 first");
    // R4: same page, back to back and after a short gap
    doRead(20'h00125, 1'b1, 0, "R4 in-page");
    doRead(20'h00120, 1'b1, 2, "R4 gap2");
    // R5: accepted on the cycle chip enable would drop -> still a hit
    doRead(20'h00127, 1'b1, IDLE - 1, "R5 boundary hit");
    // R5: one cycle later the page is closed
    doRead(20'h00121, 1'b0, IDLE, "R5 boundary miss");

    // R5: chip enable high after a long idle
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    for (int i = 0; i < IDLE + 2; i++) @(negedge clk);
    check(memCeN && memOeN, "R5", "deselected after idle", {memCeN, memOeN}, 3);
    // R6: same address after reselect takes the full wait
    doRead(20'h00121, 1'b0, 0, "R6 same addr");
    doRead(20'h00126, 1'b1, 0, "R6 then in-page");

    // R2: page changes and boundaries
    doRead(20'h00BC8, 1'b0, 0, "R2 new page");
    doRead(20'h00BC8, 1'b1, 0, "R4 repeat addr");
    doRead(20'h00BCF, 1'b1, 0, "R2 last word");
    doRead(20'h00BD0, 1'b0, 0, "R2 next page");
    doRead(20'h80BD3, 1'b0, 0, "R2 high bit differs");
    doRead(20'h80BD1, 1'b1, 1, "R4 high page hit");

    // drain
    for (int i = 0; i < 50 && q.size() != 0; i++) @(negedge clk);
    check(q.size() == 0, "R8", "all responses returned", q.size(), 0);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule